// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog timer with a byte-wide register port. Software programs two preload values, a configuration byte and a control/lock byte. Once enabled, the timer counts down through a first stage and then a second stage. It is kept alive by periodic reload writes. If the second stage runs out, the block sets a sticky timeout flag and can pulse a reset request to the system reset logic.

Writes to the preload bytes and to the reload/status byte are guarded. A two-byte key must be written to the key offset just before each such write. Any other guarded write is dropped. A lock bit freezes the configuration and the enable until the next system reset. The timeout flag lives on a separate power-on reset, so after a watchdog-caused system reset it still reports why the system restarted.

The down counter advances once per prescaler tick. A coarse tick lasts 2^COARSE_LOG2 clock cycles and a fine tick lasts 2^FINE_LOG2 clock cycles. A preload value N lasts N+1 ticks.

Top module: `wdt_keyed_twostage`

## Requirements
- R1: Writing 0x80 and then 0x86 to offset 0x0C opens the key for exactly one guarded write. The guarded offsets are 0x00-0x03 (first preload, byte 0 least significant), 0x04-0x07 (second preload) and 0x0D (reload/status). Any guarded write closes the key again.
- R2: A guarded write made while the key is not open changes nothing and returns the key sequencer to idle. A write to 0x0C of any value other than the expected next key byte also returns it to idle. A repeated 0x80 restarts the sequence.
- R3: Configuration bit 2 at 0x10 selects the tick period: 0 gives 2^COARSE_LOG2 clock cycles per tick, and 1 gives 2^FINE_LOG2 clock cycles per tick.
- R4: While lock-byte bit 1 (enable, offset 0x18) is 0, the counter is held at the first preload and the prescaler is cleared. While it is 1, the counter drops by one per tick, so a preload of N lasts N+1 ticks, including N = 0.
- R5: When the first stage runs out, the counter loads the second preload and the stage2 output goes high.
- R6: When the second stage runs out, the timeout flag (bit 1 at 0x0D) is set. rst_req pulses high for one cycle if configuration bit 4 is set. The tmo_pin output equals the flag ANDed with configuration bit 5. The rst_cold output follows configuration bit 3.
- R7: After a timeout, lock-byte bit 2 set restarts the first stage from its preload. With bit 2 clear, the counter halts until it is reloaded or disabled.
- R8: A guarded write to 0x0D with bit 0 set restarts the first stage from the first preload and clears the prescaler.
- R9: A guarded write to 0x0D with bit 1 set clears the timeout flag. A timeout in the same cycle wins. The flag is kept through rst_n and is cleared only by por_n.
- R10: Once lock-byte bit 0 is 1, writes to 0x10 and 0x18 are ignored until rst_n or por_n.
- R11: Reads are combinational. 0x00-0x07 return the preload bytes, 0x14-0x17 return the bytes of the current count, 0x10 returns the configuration bits in place, 0x18 returns the lock byte, and 0x0D returns the flag in bit 1. Every other offset, and every byte above the counter width, reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including the timeout flag |
| rst_n | input | 1 | System reset, active low, clears everything except the timeout flag |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 5 | Byte offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| stage2 | output | 1 | High while the second stage is active or halted after a timeout |
| rst_req | output | 1 | One-cycle reset request on timeout |
| rst_cold | output | 1 | Requested reset type |
| tmo_pin | output | 1 | Timeout indication output |

## Verification
A behavioural reference model in the bench steps with every clock and predicts the outputs, the count and the flag.

The key sequencer is exercised with four patterns: the correct pair, a wrong second byte, an unprotected write between the two key bytes, and a second guarded write after one accepted write. Together they separate "key accepted" from "key held open" and from "key ignored".

The countdown runs four ways:
- In fine mode with separate stage lengths, which distinguishes a stage-1 expiry from a stage-2 expiry.
- With regular reloads, which must never reach stage 2.
- With the restart bit set, which must give repeated timeouts.
- In coarse mode with a zero first preload, which checks the tick period and the N+1 count.

Lock, system reset and power-on reset are applied in turn, so that the flag's reset domain is told apart from the lock's.

// File: rtl/wdt_keyed_twostage.sv
module wdt_keyed_twostage #(
  parameter int CNT_W       = 20,
  parameter int COARSE_LOG2 = 15,
  parameter int FINE_LOG2   = 5
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       stage2,
  output logic       rst_req,
  output logic       rst_cold,
  output logic       tmo_pin
);

  localparam logic [4:0] A_KEY = 5'h0C;
  localparam logic [4:0] A_CTL = 5'h0D;
  localparam logic [4:0] A_CFG = 5'h10;
  localparam logic [4:0] A_LCK = 5'h18;
  localparam logic [7:0] KEY_A = 8'h80;
  localparam logic [7:0] KEY_B = 8'h86;
  localparam logic [COARSE_LOG2-1:0] HI_MASK = {COARSE_LOG2{1'b1}} << FINE_LOG2;

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_OPEN} key_t;

  key_t             key_q;
  logic [CNT_W-1:0] pv1_q, pv2_q, cnt_q;
  logic [3:0]       cfg_q;
  logic [2:0]       lock_q;
  logic [COARSE_LOG2-1:0] pre_q;
  logic             stage_q, done_q, flag_q;

  logic rst_all_n;
  assign rst_all_n = por_n & rst_n;

  function automatic logic [CNT_W-1:0] put_byte(logic [CNT_W-1:0] old, logic [1:0] idx,
                                                logic [7:0] b);
    logic [31:0] w;
    w = 32'(old);
    w[idx*8 +: 8] = b;
    return w[CNT_W-1:0];
  endfunction

  function automatic logic [7:0] get_byte(logic [CNT_W-1:0] v, logic [1:0] idx);
    logic [31:0] w;
    w = 32'(v);
    return w[idx*8 +: 8];
  endfunction

  logic key_wr, prot_hit, prot_ok, reload, flag_clr, cfg_wr, lock_wr;
  assign key_wr   = wr_en && addr == A_KEY;
  assign prot_hit = wr_en && (addr[4:3] == 2'b00 || addr == A_CTL);
  assign prot_ok  = prot_hit && key_q == K_OPEN;
  assign reload   = prot_ok && addr == A_CTL && wr_data[0];
  assign flag_clr = prot_ok && addr == A_CTL && wr_data[1];
  assign cfg_wr   = wr_en && addr == A_CFG && !lock_q[0];
  assign lock_wr  = wr_en && addr == A_LCK && !lock_q[0];

  logic en, tick, expire;
  assign en     = lock_q[1];
  assign tick   = &(pre_q | (cfg_q[0] ? HI_MASK : '0));
  assign expire = rst_all_n && en && !done_q && !reload && tick && cnt_q == '0 && stage_q;

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      key_q <= K_IDLE;
    end else if (key_wr) begin
      if (wr_data == KEY_A)                        key_q <= K_HALF;
      else if (key_q == K_HALF && wr_data == KEY_B) key_q <= K_OPEN;
      else                                         key_q <= K_IDLE;
    end else if (prot_hit) begin
      key_q <= K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      pv1_q  <= '0;
      pv2_q  <= '0;
      cfg_q  <= '0;
      lock_q <= '0;
    end else begin
      if (prot_ok && addr[4:2] == 3'd0) pv1_q <= put_byte(pv1_q, addr[1:0], wr_data);
      if (prot_ok && addr[4:2] == 3'd1) pv2_q <= put_byte(pv2_q, addr[1:0], wr_data);
      if (cfg_wr)  cfg_q  <= wr_data[5:2];
      if (lock_wr) lock_q <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      cnt_q   <= '0;
      stage_q <= 1'b0;
      done_q  <= 1'b0;
      pre_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (reload || !en) begin
        cnt_q   <= pv1_q;
        stage_q <= 1'b0;
        done_q  <= 1'b0;
        pre_q   <= '0;
      end else if (!done_q) begin
        pre_q <= pre_q + 1'b1;
        if (tick) begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!stage_q) begin
            cnt_q   <= pv2_q;
            stage_q <= 1'b1;
          end else begin
            rst_req <= cfg_q[2];
            if (lock_q[2]) begin
              cnt_q   <= pv1_q;
              stage_q <= 1'b0;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    rd_data = 8'h00;
    unique casez (addr)
      5'b000??: rd_data = get_byte(pv1_q, addr[1:0]);
      5'b001??: rd_data = get_byte(pv2_q, addr[1:0]);
      5'b101??: rd_data = get_byte(cnt_q, addr[1:0]);
      A_CTL:    rd_data = {6'b0, flag_q, 1'b0};
      A_CFG:    rd_data = {2'b0, cfg_q, 2'b0};
      A_LCK:    rd_data = {5'b0, lock_q};
      default:  rd_data = 8'h00;
    endcase
  end

  assign stage2   = stage_q;
  assign rst_cold = cfg_q[1];
  assign tmo_pin  = flag_q & cfg_q[3];

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
    rst_req |=> !rst_req);
  assert_req_after_stage2_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
    rst_req |-> $past(stage_q));
  assert_key_consumed_R1: assert property (@(posedge clk) disable iff (!rst_all_n)
    prot_hit |=> key_q == K_IDLE);
  assert_lock_freeze_R10: assert property (@(posedge clk) disable iff (!rst_all_n)
    lock_q[0] |=> (lock_q == $past(lock_q) && cfg_q == $past(cfg_q)));
  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_all_n)
    !en |=> (!stage_q && !done_q && pre_q == '0));
  assert_flag_rise_R9: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(flag_q) |-> $past(stage_q));
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_all_n)
    reload |=> (cnt_q == $past(pv1_q) && !stage_q));

endmodule

// File: tb/wdt_keyed_twostage_test.sv
module wdt_keyed_twostage_test;
  localparam int CW = 12;
  localparam int CL = 6;
  localparam int FL = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       por_n = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       stage2, rst_req, rst_cold, tmo_pin;

  wdt_keyed_twostage #(.CNT_W(CW), .COARSE_LOG2(CL), .FINE_LOG2(FL)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .stage2(stage2), .rst_req(rst_req),
    .rst_cold(rst_cold), .tmo_pin(tmo_pin));

  int checks = 0, failures = 0, pulses = 0;
  bit cmp_on = 0;

  int m_pv1, m_pv2, m_cfg, m_lock, m_key, m_cnt, m_pre;
  bit m_flag, m_stage, m_done, m_req;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int opv1, opv2, ocfg, olock, sh;
    bit prot, ok, rl, tick;
    if (!por_n) begin
      m_pv1 = 0; m_pv2 = 0; m_cfg = 0; m_lock = 0; m_key = 0; m_cnt = 0; m_pre = 0;
      m_flag = 0; m_stage = 0; m_done = 0; m_req = 0;
    end else if (!rst_n) begin
      m_pv1 = 0; m_pv2 = 0; m_cfg = 0; m_lock = 0; m_key = 0; m_cnt = 0; m_pre = 0;
      m_stage = 0; m_done = 0; m_req = 0;
    end else begin
      opv1 = m_pv1; opv2 = m_pv2; ocfg = m_cfg; olock = m_lock;
      prot = wr_en && (addr < 8 || addr == 13);
      ok   = prot && m_key == 2;
      if (wr_en && addr == 12)
        m_key = (wr_data == 8'h80) ? 1 : (m_key == 1 && wr_data == 8'h86) ? 2 : 0;
      else if (prot) m_key = 0;
      if (ok && addr < 4) begin
        sh = 8 * int'(addr);
        m_pv1 = ((m_pv1 & ~(255 << sh)) | (int'(wr_data) << sh)) & ((1 << CW) - 1);
      end
      if (ok && addr >= 4 && addr < 8) begin
        sh = 8 * (int'(addr) - 4);
        m_pv2 = ((m_pv2 & ~(255 << sh)) | (int'(wr_data) << sh)) & ((1 << CW) - 1);
      end
      if (wr_en && addr == 16 && (olock & 1) == 0) m_cfg = int'(wr_data) & 'h3C;
      if (wr_en && addr == 24 && (olock & 1) == 0) m_lock = int'(wr_data) & 7;
      rl = ok && addr == 13 && wr_data[0];
      if (ok && addr == 13 && wr_data[1]) m_flag = 0;
      m_req = 0;
      if (rl || (olock & 2) == 0) begin
        m_cnt = opv1; m_stage = 0; m_done = 0; m_pre = 0;
      end else if (!m_done) begin
        tick = (ocfg & 4) != 0 ? (m_pre % (1 << FL)) == (1 << FL) - 1 : m_pre == (1 << CL) - 1;
        m_pre = (m_pre + 1) % (1 << CL);
        if (tick) begin
          if (m_cnt != 0) m_cnt = m_cnt - 1;
          else if (!m_stage) begin m_cnt = opv2; m_stage = 1; end
          else begin
            m_flag = 1;
            m_req  = (ocfg & 'h10) != 0;
            if ((olock & 4) != 0) begin m_cnt = opv1; m_stage = 0; end
            else m_done = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R5 R6 outputs {stage2,rst_req,rst_cold,tmo_pin}",
          {stage2, rst_req, rst_cold, tmo_pin},
          {m_stage, m_req, (m_cfg & 8) != 0, m_flag && (m_cfg & 'h20) != 0});
      if (rst_req) pulses++;
    end
  end

  function automatic int mread(int a);
    if (a < 4)                return (m_pv1 >> (8 * a)) & 255;
    if (a < 8)                return (m_pv2 >> (8 * (a - 4))) & 255;
    if (a == 13)              return m_flag ? 2 : 0;
    if (a == 16)              return m_cfg;
    if (a >= 20 && a < 24)    return (m_cnt >> (8 * (a - 20))) & 255;
    if (a == 24)              return m_lock;
    return 0;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic kwr(int a, int d);
    wr(12, 'h80); wr(12, 'h86); wr(a, d);
  endtask

  task automatic rdc(int a, string tag);
    @(negedge clk);
    addr = 5'(a);
    #1 chk(tag, int'(rd_data), mread(a));
  endtask

  task automatic rdx(int a, int exp, string tag);
    rdc(a, tag);
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 por_n = 1'b1; rst_n = 1'b1;
    cmp_on = 1;

    rdx(0, 0, "R11 reset pv1");   rdx(4, 0, "R11 reset pv2");
    rdx(13, 0, "R11 reset flag"); rdx(16, 0, "R11 reset cfg");
    rdx(20, 0, "R11 reset cnt");  rdx(24, 0, "R11 reset lock");
    rdx(12, 0, "R11 key offset reads 0");

    kwr(0, 'h05); rdx(0, 5, "R1 keyed write pv1");
    wr(4, 'h33);  rdx(4, 0, "R2 unkeyed write ignored");
    wr(12, 'h80); wr(12, 'h85); wr(4, 'h33); rdx(4, 0, "R2 bad second key byte");
    wr(12, 'h80); wr(16, 0); wr(12, 'h86); wr(4, 'h11); rdx(4, 'h11, "R1 unguarded write keeps key");
    kwr(4, 2); wr(4, 7); rdx(4, 2, "R1 key is single use");
    wr(12, 'h80); wr(12, 'h80); wr(12, 'h86); wr(5, 0); rdx(5, 0, "R2 repeated first key byte");
    kwr(1, 'h01); rdx(1, 1, "R11 pv1 byte 1"); rdx(2, 0, "R11 byte above width");
    kwr(1, 0);

    wr(16, 'h3C); rdx(16, 'h3C, "R11 cfg readback");
    wr(24, 2);
    for (int i = 0; i < 24; i++) rdc(20, "R4 R11 count during stage 1");
    for (int i = 0; i < 12; i++) rdc(20, "R5 count during stage 2");
    idle(20);
    rdx(13, 2, "R6 flag set after stage 2");
    chk("R6 tmo_pin", int'(tmo_pin), 1);
    chk("R6 rst_req pulse count", pulses, 1);
    rdc(20, "R7 halted count");

    kwr(13, 2); rdx(13, 0, "R9 flag cleared");
    wr(24, 0); rdc(20, "R4 held at preload");
    wr(24, 2);
    for (int r = 0; r < 8; r++) begin idle(12); kwr(13, 1); end
    rdx(13, 0, "R8 reload keeps flag clear");
    chk("R8 stage2 not reached", int'(stage2), 0);

    pulses = 0;
    wr(24, 6); idle(200);
    chk("R7 restart gives repeated timeouts", int'(pulses >= 3), 1);

    wr(24, 0); wr(16, 'h10);
    kwr(0, 0); kwr(4, 1); kwr(13, 2);
    wr(24, 2);
    idle(64 * 3 - 8);
    rdx(13, 0, "R3 coarse not yet expired");
    idle(20);
    rdx(13, 2, "R3 R4 coarse expiry with zero first preload");

    wr(24, 3); wr(16, 0); rdx(16, 'h10, "R10 cfg frozen");
    wr(24, 0); rdx(24, 3, "R10 lock frozen");

    wr(13, 2); rdx(13, 2, "R2 unkeyed flag clear ignored");

    @(negedge clk); #1 rst_n = 1'b0; @(posedge clk); @(negedge clk); #1 rst_n = 1'b1;
    rdx(13, 2, "R9 flag survives rst_n");
    rdx(24, 0, "R10 lock cleared by rst_n");
    @(negedge clk); #1 por_n = 1'b0; @(posedge clk); @(negedge clk); #1 por_n = 1'b1;
    rdx(13, 0, "R9 flag cleared by por_n");

    idle(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule